// File: doc/BRIEF.md
# Shared Multi-Context Interrupt Controller

This block gathers a parameterised set of external interrupt sources and delivers them to several processor contexts. Each source has its own sense (active-high or active-low), its own trigger style (level or edge), a mask bit, a choice of one output pin and a bitmask of the contexts it reaches. A source can instead be sent to a per-context non-maskable line. Software can force any source pending, or clear a latched edge, through a single command register. Bit 31 of that register picks whether the source is set or cleared.

Software reaches everything through a simple synchronous register port with word addresses. Writes take effect at the clock edge that accepts them. Read data appears one cycle after the read strobe. Each context receives a vector of normal interrupt pins and one non-maskable line, and all of these outputs are registered.

Top module: `irq_hub`

## Requirements
- R1: After reset, all sources are active-high, level-triggered, masked and unrouted. Every control word at 0xC0+s reads 0, and `ctx_pin` and `ctx_nmi` are low.
- R2: Address 0x00 is read-only. It returns NUM_SRC/8-1 in bits [7:0], NUM_CTX in bits [15:8], NUM_PIN in bits [23:16] and zero in all other bits.
- R3: The control word at 0xC0+s holds an invert bit in bit 0 and an edge bit in bit 1. With the edge bit clear, source s is pending exactly while `irq_src[s]` XOR invert is 1.
- R4: With the edge bit set, a 0-to-1 transition of the active value latches the pending state of source s. The latched state stays until it is cleared through the command register, and an input held active does not pend the source again.
- R5: A write to 0x01 acts on the source whose number is in bits [7:0]. Bit 31 = 1 sets that source pending, and bit 31 = 0 clears its latched pending state. Writes on consecutive cycles are each applied, and a read issued in the cycle after a write already reflects it.
- R6: A write to 0x02 sets the mask-enable bit of the source numbered in data bits [7:0], and a write to 0x03 clears it. A source whose bit is clear drives no normal pin. Enable bits read as packed words at 0x18+w.
- R7: Pending state reads as packed words at 0x10+w, with bit i of word w being source 32*w+i. Bits and words beyond the implemented sources read 0.
- R8: The route word at 0x40+s holds a normal-route enable in bit 31 and a pin number in bits [PIN_W-1:0]. The context word at 0x80+s holds context c in bit c. `ctx_pin[c*NUM_PIN+p]` is high one cycle after any pending, enabled source without the NMI flag is routed to pin p with context bit c set.
- R9: When bit 30 of the route word at 0x40+s is set, source s goes to `ctx_nmi[c]` for every context c in its context word, whatever its mask bit, and never to a normal pin.
- R10: Register writes and command writes that name a source number at or above NUM_SRC change nothing, and reads of per-source words for such numbers return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 8 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after `bus_rd` |
| irq_src | input | NUM_SRC | External interrupt inputs, synchronous to `clk` |
| ctx_pin | output | NUM_CTX*NUM_PIN | Normal interrupt pins, context-major |
| ctx_nmi | output | NUM_CTX | Non-maskable line per context |

## Verification
The assertions rely on `irq_src` already being synchronous to `clk`. They also rely on software never issuing a read and a write in the same cycle and never naming a source above 255 in a command. The bench meets these conditions by changing inputs only at falling edges and by using one strobe per bus task. It also keeps every command source number below 32. Before it switches a source into edge mode, the bench drives that source's input inactive, so the polarity change creates no transition that the expected values do not account for.

// File: rtl/irq_hub_pkg.sv
package irq_hub_pkg;
  localparam logic [7:0] ADR_CFG   = 8'h00;
  localparam logic [7:0] ADR_WEDGE = 8'h01;
  localparam logic [7:0] ADR_MSET  = 8'h02;
  localparam logic [7:0] ADR_MCLR  = 8'h03;
  localparam logic [4:0] ADR_PEND_W = 5'b00010;  // 0x10..0x17
  localparam logic [4:0] ADR_MASK_W = 5'b00011;  // 0x18..0x1F
  localparam logic [1:0] RGN_MAP = 2'd1;          // 0x40 + s
  localparam logic [1:0] RGN_CTX = 2'd2;          // 0x80 + s
  localparam logic [1:0] RGN_CTL = 2'd3;          // 0xC0 + s
  localparam int WEDGE_SET_BIT = 31;
  localparam int MAP_EN_BIT    = 31;
  localparam int MAP_NMI_BIT   = 30;
  localparam int CTL_INV_BIT   = 0;
  localparam int CTL_EDGE_BIT  = 1;
endpackage

// File: rtl/irq_hub_srcbank.sv
module irq_hub_srcbank #(
  parameter int NUM_SRC = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] irq_src,
  input  logic [NUM_SRC-1:0] invert,
  input  logic [NUM_SRC-1:0] edge_mode,
  input  logic [NUM_SRC-1:0] sw_set,
  input  logic [NUM_SRC-1:0] sw_clr,
  output logic [NUM_SRC-1:0] pend
);
  logic [NUM_SRC-1:0] act, act_d, latch_q, edge_evt;

  assign act      = irq_src ^ invert;
  assign edge_evt = edge_mode & act & ~act_d;

  // A set (edge or software) in the same cycle as a clear wins: no event lost.
  always_ff @(posedge clk) begin
    if (rst) begin
      act_d   <= '0;
      latch_q <= '0;
    end else begin
      act_d   <= act;
      latch_q <= (latch_q & ~sw_clr) | sw_set | edge_evt;
    end
  end

  assign pend = latch_q | (~edge_mode & act);
endmodule

// File: rtl/irq_hub_router.sv
module irq_hub_router #(
  parameter int NUM_SRC = 16,
  parameter int NUM_CTX = 4,
  parameter int NUM_PIN = 4,
  parameter int PIN_W   = 2
) (
  input  logic                                clk,
  input  logic                                rst,
  input  logic [NUM_SRC-1:0]                  pend,
  input  logic [NUM_SRC-1:0]                  mask,
  input  logic [NUM_SRC-1:0]                  map_en,
  input  logic [NUM_SRC-1:0]                  map_nmi,
  input  logic [NUM_SRC-1:0][PIN_W-1:0]       map_pin,
  input  logic [NUM_SRC-1:0][NUM_CTX-1:0]     ctx_msk,
  output logic [NUM_CTX*NUM_PIN-1:0]          pin_q,
  output logic [NUM_CTX-1:0]                  nmi_q
);
  logic [NUM_SRC-1:0]         live_pin, live_nmi;
  logic [NUM_CTX*NUM_PIN-1:0] pin_d;
  logic [NUM_CTX-1:0]         nmi_d;

  assign live_pin = pend & mask & map_en & ~map_nmi;
  assign live_nmi = pend & map_nmi;

  for (genvar c = 0; c < NUM_CTX; c++) begin : g_ctx
    for (genvar p = 0; p < NUM_PIN; p++) begin : g_pin
      logic hit;
      always_comb begin
        hit = 1'b0;
        for (int s = 0; s < NUM_SRC; s++)
          hit = hit | (live_pin[s] & ctx_msk[s][c] & (map_pin[s] == PIN_W'(p)));
      end
      assign pin_d[c*NUM_PIN+p] = hit;
    end
    logic nhit;
    always_comb begin
      nhit = 1'b0;
      for (int s = 0; s < NUM_SRC; s++)
        nhit = nhit | (live_nmi[s] & ctx_msk[s][c]);
    end
    assign nmi_d[c] = nhit;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pin_q <= '0;
      nmi_q <= '0;
    end else begin
      pin_q <= pin_d;
      nmi_q <= nmi_d;
    end
  end
endmodule

// File: rtl/irq_hub.sv
module irq_hub
  import irq_hub_pkg::*;
#(
  parameter int NUM_SRC = 16,
  parameter int NUM_CTX = 4,
  parameter int NUM_PIN = 4
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       bus_wr,
  input  logic                       bus_rd,
  input  logic [7:0]                 bus_addr,
  input  logic [31:0]                bus_wdata,
  output logic [31:0]                bus_rdata,
  input  logic [NUM_SRC-1:0]         irq_src,
  output logic [NUM_CTX*NUM_PIN-1:0] ctx_pin,
  output logic [NUM_CTX-1:0]         ctx_nmi
);
  // NUM_SRC: multiple of 8, at most 64. NUM_CTX at most 32.
  localparam int SW    = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;
  localparam int PIN_W = (NUM_PIN > 1) ? $clog2(NUM_PIN) : 1;
  localparam logic [7:0]  NSRC8   = 8'(NUM_SRC);
  localparam logic [31:0] CFG_VAL = {8'h00, 8'(NUM_PIN), 8'(NUM_CTX), 8'(NUM_SRC/8 - 1)};

  logic [NUM_SRC-1:0]             mask_q, inv_q, edge_q, map_en, map_nmi;
  logic [NUM_SRC-1:0][PIN_W-1:0]  map_pin;
  logic [NUM_SRC-1:0][NUM_CTX-1:0] ctx_msk;
  logic [NUM_SRC-1:0]             sw_set, sw_clr, pend_w;

  // Command decode: source number in data[7:0]
  logic          cmd_ok;
  logic [SW-1:0] cmd_sel;
  assign cmd_ok  = bus_wdata[7:0] < NSRC8;
  assign cmd_sel = bus_wdata[SW-1:0];

  // Per-source register decode: source number in addr[5:0]
  logic [1:0]    rgn;
  logic          idx_ok;
  logic [SW-1:0] idx_sel;
  assign rgn     = bus_addr[7:6];
  assign idx_ok  = {2'b00, bus_addr[5:0]} < NSRC8;
  assign idx_sel = bus_addr[SW-1:0];

  always_comb begin
    sw_set = '0;
    sw_clr = '0;
    if (bus_wr && bus_addr == ADR_WEDGE && cmd_ok) begin
      if (bus_wdata[WEDGE_SET_BIT]) sw_set[cmd_sel] = 1'b1;
      else                          sw_clr[cmd_sel] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q  <= '0;
      inv_q   <= '0;
      edge_q  <= '0;
      map_en  <= '0;
      map_nmi <= '0;
      map_pin <= '0;
      ctx_msk <= '0;
    end else if (bus_wr) begin
      if (bus_addr == ADR_MSET && cmd_ok) mask_q[cmd_sel] <= 1'b1;
      if (bus_addr == ADR_MCLR && cmd_ok) mask_q[cmd_sel] <= 1'b0;
      if (idx_ok) begin
        case (rgn)
          RGN_MAP: begin
            map_en[idx_sel]  <= bus_wdata[MAP_EN_BIT];
            map_nmi[idx_sel] <= bus_wdata[MAP_NMI_BIT];
            map_pin[idx_sel] <= bus_wdata[PIN_W-1:0];
          end
          RGN_CTX: ctx_msk[idx_sel] <= bus_wdata[NUM_CTX-1:0];
          RGN_CTL: begin
            inv_q[idx_sel]  <= bus_wdata[CTL_INV_BIT];
            edge_q[idx_sel] <= bus_wdata[CTL_EDGE_BIT];
          end
          default: ;
        endcase
      end
    end
  end

  // Read path
  logic [255:0] pend_pad, mask_pad;
  logic [31:0]  rd_val;
  assign pend_pad = 256'(pend_w);
  assign mask_pad = 256'(mask_q);

  always_comb begin
    rd_val = '0;
    case (rgn)
      2'd0: begin
        if (bus_addr == ADR_CFG)            rd_val = CFG_VAL;
        else if (bus_addr[7:3] == ADR_PEND_W) rd_val = pend_pad[{bus_addr[2:0], 5'b0} +: 32];
        else if (bus_addr[7:3] == ADR_MASK_W) rd_val = mask_pad[{bus_addr[2:0], 5'b0} +: 32];
      end
      RGN_MAP: if (idx_ok) begin
        rd_val[MAP_EN_BIT]  = map_en[idx_sel];
        rd_val[MAP_NMI_BIT] = map_nmi[idx_sel];
        rd_val[PIN_W-1:0]   = map_pin[idx_sel];
      end
      RGN_CTX: if (idx_ok) rd_val[NUM_CTX-1:0] = ctx_msk[idx_sel];
      RGN_CTL: if (idx_ok) begin
        rd_val[CTL_INV_BIT]  = inv_q[idx_sel];
        rd_val[CTL_EDGE_BIT] = edge_q[idx_sel];
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_val;
  end

  irq_hub_srcbank #(.NUM_SRC(NUM_SRC)) u_bank (
    .clk(clk), .rst(rst), .irq_src(irq_src), .invert(inv_q),
    .edge_mode(edge_q), .sw_set(sw_set), .sw_clr(sw_clr), .pend(pend_w)
  );

  irq_hub_router #(
    .NUM_SRC(NUM_SRC), .NUM_CTX(NUM_CTX), .NUM_PIN(NUM_PIN), .PIN_W(PIN_W)
  ) u_route (
    .clk(clk), .rst(rst), .pend(pend_w), .mask(mask_q), .map_en(map_en),
    .map_nmi(map_nmi), .map_pin(map_pin), .ctx_msk(ctx_msk),
    .pin_q(ctx_pin), .nmi_q(ctx_nmi)
  );
endmodule

// File: rtl/irq_hub_chk.sv
module irq_hub_chk
  import irq_hub_pkg::*;
#(
  parameter int NUM_SRC = 16,
  parameter int NUM_CTX = 4,
  parameter int NUM_PIN = 4
) (
  input logic                       clk,
  input logic                       rst,
  input logic                       bus_wr,
  input logic                       bus_rd,
  input logic [7:0]                 bus_addr,
  input logic [31:0]                bus_wdata,
  input logic [31:0]                bus_rdata,
  input logic [NUM_CTX*NUM_PIN-1:0] ctx_pin,
  input logic [NUM_CTX-1:0]         ctx_nmi,
  input logic [NUM_SRC-1:0]         pend,
  input logic [NUM_SRC-1:0]         mask,
  input logic [NUM_SRC-1:0]         edge_mode
);
  localparam int SW = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;
  localparam logic [7:0] NSRC8 = 8'(NUM_SRC);
  localparam logic [31:0] CFG_EXP = (32'(NUM_PIN) << 16) | (32'(NUM_CTX) << 8) | 32'(NUM_SRC/8 - 1);

  logic wedge_set_hit, wedge_clr_any;
  assign wedge_set_hit = bus_wr && bus_addr == ADR_WEDGE && bus_wdata[31] && bus_wdata[7:0] < NSRC8;
  assign wedge_clr_any = bus_wr && bus_addr == ADR_WEDGE && !bus_wdata[31];

  a_r1_reset_quiet: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (ctx_pin == '0 && ctx_nmi == '0 && mask == '0 && edge_mode == '0));

  a_r2_cfg_value: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && !bus_wr && bus_addr == ADR_CFG) |=> bus_rdata == CFG_EXP);

  a_r5_wedge_sets: assert property (@(posedge clk) disable iff (rst)
    wedge_set_hit |=> pend[$past(bus_wdata[SW-1:0])]);

  a_r6_masked_quiet: assert property (@(posedge clk) disable iff (rst)
    (mask == '0) |=> ctx_pin == '0);

  a_r10_oor_reads_zero: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && !bus_wr && bus_addr[7:6] != 2'd0 && {2'b00, bus_addr[5:0]} >= NSRC8) |=> bus_rdata == '0);

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_hold
    a_r4_edge_hold: assert property (@(posedge clk) disable iff (rst)
      (edge_mode[s] && pend[s] && !(wedge_clr_any && bus_wdata[7:0] == 8'(s))) |=> pend[s]);
  end
endmodule

bind irq_hub irq_hub_chk #(
  .NUM_SRC(NUM_SRC), .NUM_CTX(NUM_CTX), .NUM_PIN(NUM_PIN)
) u_chk (
  .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ctx_pin(ctx_pin), .ctx_nmi(ctx_nmi),
  .pend(pend_w), .mask(mask_q), .edge_mode(edge_q)
);

// File: tb/irq_hub_test.sv
`timescale 1ns/1ps
module irq_hub_test;
  localparam int NS = 16;
  localparam int NC = 4;
  localparam int NP = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [NS-1:0] irq_src = '0;
  logic [NC*NP-1:0] ctx_pin;
  logic [NC-1:0] ctx_nmi;

  int n_chk = 0;
  int n_fail = 0;
  logic [31:0] rv;

  always #5 clk = ~clk;

  irq_hub #(.NUM_SRC(NS), .NUM_CTX(NC), .NUM_PIN(NP)) uut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_src(irq_src),
    .ctx_pin(ctx_pin), .ctx_nmi(ctx_nmi)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic settle();
    repeat (2) @(negedge clk);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  // Expected pin bit for source s under the sweep routing
  function automatic int pin_bit(input int s);
    return ((s / NP) % NC) * NP + (s % NP);
  endfunction

  initial begin
    repeat (50000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    chk("R1 pins", 64'(ctx_pin), 0);
    chk("R1 nmi", 64'(ctx_nmi), 0);
    rd(8'h18, rv); chk("R1 masked", 64'(rv), 0);
    for (int s = 0; s < NS; s++) begin
      rd(8'(8'hC0 + s), rv); chk("R1 ctl", 64'(rv), 0);
    end

    // R2 configuration word
    rd(8'h00, rv); chk("R2 cfg", 64'(rv), 64'(((NP) << 16) | (NC << 8) | (NS/8 - 1)));

    // R8 routing setup with readback
    for (int s = 0; s < NS; s++) begin
      wr(8'(8'h40 + s), 32'h8000_0000 | 32'(s % NP));
      wr(8'(8'h80 + s), 32'(1 << ((s / NP) % NC)));
      rd(8'(8'h40 + s), rv); chk("R8 map rb", 64'(rv), 64'(32'h8000_0000 | 32'(s % NP)));
      rd(8'(8'h80 + s), rv); chk("R8 ctx rb", 64'(rv), 64'(1 << ((s / NP) % NC)));
    end

    // R6/R3: all inputs active but masked
    irq_src = '1; settle();
    chk("R6 masked pins", 64'(ctx_pin), 0);
    rd(8'h10, rv); chk("R3 level pend", 64'(rv), 64'hFFFF);
    rd(8'h11, rv); chk("R7 word beyond", 64'(rv), 0);
    irq_src = '0;
    for (int s = 0; s < NS; s++) wr(8'h02, 32'(s));
    rd(8'h18, rv); chk("R6 mask word", 64'(rv), 64'hFFFF);

    // R8 sweep: one source at a time
    for (int s = 0; s < NS; s++) begin
      irq_src = NS'(1) << s; settle();
      chk("R8 sweep", 64'(ctx_pin), 64'(1) << pin_bit(s));
      irq_src = '0; settle();
      chk("R3 level drop", 64'(ctx_pin), 0);
    end
    irq_src = '1; settle();
    chk("R8 all", 64'(ctx_pin), 64'hFFFF);
    irq_src = '0; settle();

    // R3 inversion on source 3
    wr(8'hC3, 32'h1); settle();
    chk("R3 invert", 64'(ctx_pin), 64'(1) << pin_bit(3));
    rd(8'h10, rv); chk("R7 pend word", 64'(rv), 64'h8);
    irq_src[3] = 1'b1; settle();
    chk("R3 invert high", 64'(ctx_pin), 0);
    wr(8'hC3, 32'h0); irq_src[3] = 1'b0; settle();

    // R4 edge latch on source 5
    wr(8'hC5, 32'h2); settle();
    chk("R4 idle", 64'(ctx_pin), 0);
    @(negedge clk) irq_src[5] = 1'b1;
    @(negedge clk) irq_src[5] = 1'b0;
    settle();
    chk("R4 latched", 64'(ctx_pin), 64'(1) << pin_bit(5));
    rd(8'h10, rv); chk("R4 pend", 64'(rv), 64'h20);
    wr(8'h01, 32'd5); settle();
    chk("R4 cleared", 64'(ctx_pin), 0);
    irq_src[5] = 1'b1; settle();
    chk("R4 relatch", 64'(ctx_pin), 64'(1) << pin_bit(5));
    wr(8'h01, 32'd5); settle();
    chk("R4 held input no repend", 64'(ctx_pin), 0);
    irq_src[5] = 1'b0; settle();
    wr(8'hC5, 32'h0);

    // R5 software set/clear
    wr(8'h01, 32'h8000_0007); settle();
    chk("R5 set pin", 64'(ctx_pin), 64'(1) << pin_bit(7));
    @(negedge clk); bus_wr = 1'b1; bus_addr = 8'h01; bus_wdata = 32'h8000_0008;
    @(negedge clk); bus_wdata = 32'h8000_0009;
    @(negedge clk); bus_wdata = 32'h0000_0007;
    @(negedge clk); bus_wr = 1'b0;
    rd(8'h10, rv); chk("R5 back-to-back", 64'(rv), 64'h300);
    @(negedge clk); bus_wr = 1'b1; bus_addr = 8'h01; bus_wdata = 32'h0000_0008;
    @(negedge clk); bus_wdata = 32'h0000_0009;
    @(negedge clk); bus_wr = 1'b0;
    rd(8'h10, rv); chk("R5 clear b2b", 64'(rv), 0);
    settle();
    chk("R5 pins idle", 64'(ctx_pin), 0);

    // R6 mask clear / set
    wr(8'h01, 32'h8000_0002); settle();
    chk("R6 on", 64'(ctx_pin), 64'(1) << pin_bit(2));
    wr(8'h03, 32'd2); settle();
    chk("R6 off", 64'(ctx_pin), 0);
    rd(8'h18, rv); chk("R6 word", 64'(rv), 64'hFFFB);
    rd(8'h10, rv); chk("R6 still pending", 64'(rv), 64'h4);
    wr(8'h02, 32'd2); settle();
    chk("R6 back", 64'(ctx_pin), 64'(1) << pin_bit(2));
    wr(8'h01, 32'd2); settle();

    // R9 non-maskable route on source 10
    wr(8'h4A, 32'h4000_0000);
    wr(8'h8A, 32'hF);
    wr(8'h03, 32'd10);
    wr(8'h01, 32'h8000_000A); settle();
    chk("R9 nmi", 64'(ctx_nmi), 64'hF);
    chk("R9 no pin", 64'(ctx_pin), 0);
    wr(8'h01, 32'd10); settle();
    chk("R9 nmi off", 64'(ctx_nmi), 0);

    // R10 out-of-range numbers
    wr(8'h54, 32'h8000_0001);
    rd(8'h54, rv); chk("R10 map read", 64'(rv), 0);
    rd(8'h94, rv); chk("R10 ctx read", 64'(rv), 0);
    rd(8'hD4, rv); chk("R10 ctl read", 64'(rv), 0);
    wr(8'h01, 32'h8000_0014);
    wr(8'h02, 32'd20); settle();
    chk("R10 pins", 64'(ctx_pin), 0);
    chk("R10 nmi", 64'(ctx_nmi), 0);
    rd(8'h10, rv); chk("R10 pend0", 64'(rv), 0);
    rd(8'h11, rv); chk("R10 pend1", 64'(rv), 0);
    rd(8'h18, rv); chk("R10 mask0", 64'(rv), 64'hFBFF);
    rd(8'h19, rv); chk("R10 mask1", 64'(rv), 0);

    summary();
    $finish;
  end
endmodule